// File: doc/BRIEF.md
# IEEE 802.15.4 Receive Frame Filter

This block sits at the end of a low-rate wireless receive path. When the parser signals that a frame has ended, it decides, in one registered step, whether the frame is handed to software, whether the frame was addressed to this node, and whether the transmit side should send an automatic acknowledgement. The frame fields arrive already parsed: frame type, acknowledge-request bit, destination addressing mode, destination PAN identifier and destination address. The FCS verdict arrives as a single flag.

The node's identity is configured through a 16-bit short address, a 16-bit PAN identifier and a 64-bit extended address. Four control bits add non-standard behaviour. The first is a promiscuous switch, which takes effect only when the whole identity is zero. The second is a switch that suppresses every acknowledgement. The last two are a pair for reserved frame types: one admits these types at all, and the other chooses whether they pass through the same address checks as data frames or bypass the filter completely.

Software sees two sticky interrupts (end of frame, address match) that it clears through a single acknowledge input. It also sees a CRC-valid bit and a per-frame status byte that hold their value until the next frame ends.

Top module: `rx_frame_filter`

## Requirements
- R1: One cycle after `rx_done`, `irq_end` is 1. This holds for every frame, whether its FCS is good or bad. It then stays 1 until it is cleared.
- R2: One cycle after `rx_done`, `crc_valid` and `rx_status[7]` both equal `rx_fcs_ok`. The rest of `rx_status` is laid out as follows: bit 6 is the accept decision, bit 5 is the address match, bit 4 is promiscuous-active, bit 3 is the frame's ACK-request bit and bits 2:0 are the frame type. Both `crc_valid` and `rx_status` change only on `rx_done`.
- R3: The destination matches in two cases. In mode 2 (short), the PAN matches and the low 16 address bits equal `own_short` or 0xFFFF. In mode 3 (extended), the PAN matches and the 64-bit address equals `own_ext`. The PAN matches when it equals `own_pan` or 0xFFFF. Modes 0 and 1 never match.
- R4: One cycle after a matching frame ends, `irq_match` is set. This happens for any frame type, in any mode and with any FCS. A frame that does not match leaves `irq_match` unchanged.
- R5: Promiscuous mode is active when `prom_en` is 1 and `own_short`, `own_pan` and `own_ext` are all zero. While it is active, every frame is accepted. If `prom_en` is 1 but the identity is not all zero, normal filtering applies.
- R6: Outside promiscuous mode, types 0 to 3 (beacon, data, ACK, command) are accepted exactly when the destination matches.
- R7: Types 4 to 7 are reserved. Outside promiscuous mode they are rejected while `rsv_en` is 0.
- R8: With `rsv_en` at 1, reserved types follow the data rule when `rsv_as_data` is 1. When `rsv_as_data` is 0, they are accepted without address checks.
- R9: One cycle after `rx_done`, `ack_req` pulses for exactly one cycle. It pulses only when the FCS is good, the destination matches, the frame's ACK-request bit is 1 and `ack_off` is 0.
- R10: While `ack_off` is 1, `ack_req` never rises.
- R11: A cycle with `irq_clear` high clears `irq_end` and `irq_match` in the next cycle. If `rx_done` arrives in the same cycle, the new frame's interrupts win.
- R12: After reset, all outputs are 0. `frame_accept` holds its value until the next `rx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 1 | Frame-end strobe from the parser |
| rx_fcs_ok | input | 1 | FCS of the ending frame is correct |
| rx_ftype | input | 3 | Frame type field |
| rx_ack_bit | input | 1 | ACK-request bit of the frame control field |
| rx_dst_mode | input | 2 | Destination addressing mode |
| rx_dst_pan | input | 16 | Destination PAN identifier |
| rx_dst_addr | input | 64 | Destination address (short form in bits 15:0) |
| own_short | input | 16 | Own short address |
| own_pan | input | 16 | Own PAN identifier |
| own_ext | input | 64 | Own extended address |
| prom_en | input | 1 | Promiscuous enable |
| ack_off | input | 1 | Suppress all acknowledgements |
| rsv_en | input | 1 | Admit reserved frame types |
| rsv_as_data | input | 1 | Filter reserved types like data frames |
| irq_clear | input | 1 | Software acknowledge of both interrupts |
| irq_end | output | 1 | Sticky end-of-frame interrupt |
| irq_match | output | 1 | Sticky address-match interrupt |
| crc_valid | output | 1 | FCS verdict of the last frame |
| rx_status | output | 8 | Per-frame status byte |
| frame_accept | output | 1 | Last frame is delivered |
| ack_req | output | 1 | One-cycle request to send an ACK |

## Verification
Directed frames cover every distinction the filter makes. For short addressing, they use the exact own address and the broadcast address against a foreign address. Extended addressing is tried against the own 64-bit identity, and absent addressing is also covered. Each case tells a match from a miss, and bad-FCS frames show that delivery and the match interrupt do not depend on the FCS while the acknowledgement does. Reserved types are sent under all three combinations of the two reserved-type controls, with matching and foreign addresses, which separates the reject, filtered and bypass paths. A long run of random frames and configurations then mixes own, broadcast and foreign values; a behavioural model compares every output on every cycle.

// File: rtl/ffilt_pkg.sv
`timescale 1ns/1ps
package ffilt_pkg;

    // Frame type codes (frame control bits 2:0)
    typedef enum logic [2:0] {
        FT_BEACON = 3'd0,
        FT_DATA   = 3'd1,
        FT_ACK    = 3'd2,
        FT_CMD    = 3'd3,
        FT_RSV4   = 3'd4,
        FT_RSV5   = 3'd5,
        FT_RSV6   = 3'd6,
        FT_RSV7   = 3'd7
    } ftype_e;

    // Destination addressing mode
    typedef enum logic [1:0] {
        DAM_NONE  = 2'd0,
        DAM_RSVD  = 2'd1,
        DAM_SHORT = 2'd2,
        DAM_EXT   = 2'd3
    } dam_e;

    localparam int STAT_W = 8;

    // Per-frame status byte
    typedef struct packed {
        logic         crc_ok;
        logic         accepted;
        logic         matched;
        logic         prom;
        logic         ack_bit;
        ftype_e       ftype;
    } rx_stat_t;

    // Registered state of the filter
    typedef struct packed {
        logic     irq_end;
        logic     irq_match;
        logic     crc_valid;
        rx_stat_t status;
        logic     accept;
        logic     ack;
    } flt_state_t;

endpackage

// File: rtl/ffilt_cfg_zero.sv
`timescale 1ns/1ps
// Detects an all-zero node identity, one byte lane at a time.
module ffilt_cfg_zero #(
    parameter int PAN_W   = 16,
    parameter int SHORT_W = 16,
    parameter int EXT_W   = 64
) (
    input  logic [SHORT_W-1:0] own_short,
    input  logic [PAN_W-1:0]   own_pan,
    input  logic [EXT_W-1:0]   own_ext,
    output logic               all_zero
);
    localparam int NBYTES = EXT_W / 8;

    logic [NBYTES-1:0] lane_zero;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane_zero[g] = ~|own_ext[g*8 +: 8];
    end

    assign all_zero = (&lane_zero) & ~|own_short & ~|own_pan;

endmodule

// File: rtl/ffilt_addr_match.sv
`timescale 1ns/1ps
// Destination address comparison against the node identity.
module ffilt_addr_match import ffilt_pkg::*; #(
    parameter int PAN_W   = 16,
    parameter int SHORT_W = 16,
    parameter int EXT_W   = 64
) (
    input  dam_e               dst_mode,
    input  logic [PAN_W-1:0]   dst_pan,
    input  logic [EXT_W-1:0]   dst_addr,
    input  logic [SHORT_W-1:0] own_short,
    input  logic [PAN_W-1:0]   own_pan,
    input  logic [EXT_W-1:0]   own_ext,
    output logic               hit
);
    logic pan_ok;
    logic short_ok;
    logic ext_ok;

    always_comb begin
        pan_ok   = (dst_pan == own_pan) || (dst_pan == {PAN_W{1'b1}});
        short_ok = (dst_addr[SHORT_W-1:0] == own_short) ||
                   (dst_addr[SHORT_W-1:0] == {SHORT_W{1'b1}});
        ext_ok   = (dst_addr == own_ext);
        unique case (dst_mode)
            DAM_SHORT: hit = pan_ok && short_ok;
            DAM_EXT:   hit = pan_ok && ext_ok;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/ffilt_decide.sv
`timescale 1ns/1ps
// Accept and acknowledge decision for one frame.
module ffilt_decide import ffilt_pkg::*; (
    input  ftype_e ftype,
    input  logic   ack_bit,
    input  logic   hit,
    input  logic   fcs_ok,
    input  logic   prom_active,
    input  logic   rsv_en,
    input  logic   rsv_as_data,
    input  logic   ack_off,
    output logic   accept,
    output logic   ack
);
    logic is_rsv;

    always_comb begin
        is_rsv = (ftype > FT_CMD);
        if (prom_active) begin
            accept = 1'b1;
        end else if (!is_rsv) begin
            accept = hit;
        end else if (!rsv_en) begin
            accept = 1'b0;
        end else if (rsv_as_data) begin
            accept = hit;
        end else begin
            accept = 1'b1;
        end
        ack = fcs_ok && hit && ack_bit && !ack_off;
    end

endmodule

// File: rtl/rx_frame_filter.sv
`timescale 1ns/1ps
// Receive frame filter: registers the per-frame verdict and interrupts.
module rx_frame_filter import ffilt_pkg::*; #(
    parameter int PAN_W   = 16,
    parameter int SHORT_W = 16,
    parameter int EXT_W   = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_done,
    input  logic               rx_fcs_ok,
    input  logic [2:0]         rx_ftype,
    input  logic               rx_ack_bit,
    input  logic [1:0]         rx_dst_mode,
    input  logic [PAN_W-1:0]   rx_dst_pan,
    input  logic [EXT_W-1:0]   rx_dst_addr,
    input  logic [SHORT_W-1:0] own_short,
    input  logic [PAN_W-1:0]   own_pan,
    input  logic [EXT_W-1:0]   own_ext,
    input  logic               prom_en,
    input  logic               ack_off,
    input  logic               rsv_en,
    input  logic               rsv_as_data,
    input  logic               irq_clear,
    output logic               irq_end,
    output logic               irq_match,
    output logic               crc_valid,
    output logic [STAT_W-1:0]  rx_status,
    output logic               frame_accept,
    output logic               ack_req
);
    flt_state_t st_d, st_q;

    logic   id_zero;
    logic   prom_active;
    logic   hit;
    logic   acc;
    logic   ack;
    ftype_e ftype;

    assign ftype       = ftype_e'(rx_ftype);
    assign prom_active = prom_en && id_zero;

    ffilt_cfg_zero #(
        .PAN_W(PAN_W), .SHORT_W(SHORT_W), .EXT_W(EXT_W)
    ) i_cfg_zero (
        .own_short(own_short),
        .own_pan  (own_pan),
        .own_ext  (own_ext),
        .all_zero (id_zero)
    );

    ffilt_addr_match #(
        .PAN_W(PAN_W), .SHORT_W(SHORT_W), .EXT_W(EXT_W)
    ) i_addr_match (
        .dst_mode (dam_e'(rx_dst_mode)),
        .dst_pan  (rx_dst_pan),
        .dst_addr (rx_dst_addr),
        .own_short(own_short),
        .own_pan  (own_pan),
        .own_ext  (own_ext),
        .hit      (hit)
    );

    ffilt_decide i_decide (
        .ftype      (ftype),
        .ack_bit    (rx_ack_bit),
        .hit        (hit),
        .fcs_ok     (rx_fcs_ok),
        .prom_active(prom_active),
        .rsv_en     (rsv_en),
        .rsv_as_data(rsv_as_data),
        .ack_off    (ack_off),
        .accept     (acc),
        .ack        (ack)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        if (irq_clear) begin
            st_d.irq_end   = 1'b0;
            st_d.irq_match = 1'b0;
        end
        if (rx_done) begin
            st_d.irq_end           = 1'b1;
            st_d.irq_match         = st_d.irq_match | hit;
            st_d.crc_valid         = rx_fcs_ok;
            st_d.status.crc_ok     = rx_fcs_ok;
            st_d.status.accepted   = acc;
            st_d.status.matched    = hit;
            st_d.status.prom       = prom_active;
            st_d.status.ack_bit    = rx_ack_bit;
            st_d.status.ftype      = ftype;
            st_d.accept            = acc;
            st_d.ack               = ack;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_end      = st_q.irq_end;
    assign irq_match    = st_q.irq_match;
    assign crc_valid    = st_q.crc_valid;
    assign rx_status    = st_q.status;
    assign frame_accept = st_q.accept;
    assign ack_req      = st_q.ack;

endmodule

// File: rtl/rx_frame_filter_chk.sv
`timescale 1ns/1ps
// Protocol checker for the receive frame filter.
module rx_frame_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_done,
    input logic       rx_fcs_ok,
    input logic       ack_off,
    input logic       irq_clear,
    input logic       irq_end,
    input logic       irq_match,
    input logic       crc_valid,
    input logic [7:0] rx_status,
    input logic       frame_accept,
    input logic       ack_req
);
    // R1
    end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> irq_end);

    // R2
    crc_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> (crc_valid == $past(rx_fcs_ok)) && (rx_status[7] == $past(rx_fcs_ok)));

    // R2
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(crc_valid) && $stable(rx_status));

    // R9
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> !ack_req);

    // R9
    ack_fcs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && !rx_fcs_ok |=> !ack_req);

    // R10
    no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && ack_off |=> !ack_req);

    // R11
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear && !rx_done |=> !irq_end && !irq_match);

    // R12
    accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(frame_accept));

endmodule

bind rx_frame_filter rx_frame_filter_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_done     (rx_done),
    .rx_fcs_ok   (rx_fcs_ok),
    .ack_off     (ack_off),
    .irq_clear   (irq_clear),
    .irq_end     (irq_end),
    .irq_match   (irq_match),
    .crc_valid   (crc_valid),
    .rx_status   (rx_status),
    .frame_accept(frame_accept),
    .ack_req     (ack_req)
);

// File: tb/test_rx_frame_filter.sv
`timescale 1ns/1ps
module test_rx_frame_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_done = 1'b0;
    logic        rx_fcs_ok = 1'b0;
    logic [2:0]  rx_ftype = '0;
    logic        rx_ack_bit = 1'b0;
    logic [1:0]  rx_dst_mode = '0;
    logic [15:0] rx_dst_pan = '0;
    logic [63:0] rx_dst_addr = '0;
    logic [15:0] own_short = '0;
    logic [15:0] own_pan = '0;
    logic [63:0] own_ext = '0;
    logic        prom_en = 1'b0;
    logic        ack_off = 1'b0;
    logic        rsv_en = 1'b0;
    logic        rsv_as_data = 1'b0;
    logic        irq_clear = 1'b0;
    logic        irq_end, irq_match, crc_valid, frame_accept, ack_req;
    logic [7:0]  rx_status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_frame_filter i_rx_frame_filter (.*);

    // ---------------- behavioural reference model ----------------
    logic       m_end = 0, m_match = 0, m_crc = 0, m_acc = 0, m_ack = 0;
    logic [7:0] m_stat = 0;

    function automatic logic f_hit();
        logic pan;
        pan = (rx_dst_pan == own_pan) || (rx_dst_pan == 16'hFFFF);
        if (rx_dst_mode == 2'd2)
            return pan && ((rx_dst_addr[15:0] == own_short) || (rx_dst_addr[15:0] == 16'hFFFF));
        if (rx_dst_mode == 2'd3)
            return pan && (rx_dst_addr == own_ext);
        return 1'b0;
    endfunction

    function automatic logic f_prom();
        return prom_en && own_short == 0 && own_pan == 0 && own_ext == 0;
    endfunction

    function automatic logic f_acc(logic h);
        if (f_prom()) return 1'b1;
        if (rx_ftype < 3'd4) return h;
        if (!rsv_en) return 1'b0;
        if (rsv_as_data) return h;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_end <= 0; m_match <= 0; m_crc <= 0; m_acc <= 0; m_ack <= 0; m_stat <= 0;
        end else begin
            logic h, a, e, mm;
            h  = f_hit();
            a  = f_acc(h);
            e  = irq_clear ? 1'b0 : m_end;
            mm = irq_clear ? 1'b0 : m_match;
            m_ack <= 1'b0;
            if (rx_done) begin
                e  = 1'b1;
                mm = mm | h;
                m_crc  <= rx_fcs_ok;
                m_acc  <= a;
                m_ack  <= rx_fcs_ok && h && rx_ack_bit && !ack_off;
                m_stat <= {rx_fcs_ok, a, h, f_prom(), rx_ack_bit, rx_ftype};
            end
            m_end   <= e;
            m_match <= mm;
        end
    end

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({7'd0, irq_end},      {7'd0, m_end},   "R1 model irq_end");
            chk({7'd0, crc_valid},    {7'd0, m_crc},   "R2 model crc_valid");
            chk(rx_status,            m_stat,          "R2 model rx_status");
            chk({7'd0, irq_match},    {7'd0, m_match}, "R4 model irq_match");
            chk({7'd0, frame_accept}, {7'd0, m_acc},   "R6 model frame_accept");
            chk({7'd0, ack_req},      {7'd0, m_ack},   "R9 model ack_req");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send(input logic [2:0] t, input logic ab, input logic [1:0] dm,
                        input logic [15:0] dp, input logic [63:0] da, input logic fcs,
                        input logic clr = 1'b0);
        @(negedge clk); #1;
        rx_ftype = t; rx_ack_bit = ab; rx_dst_mode = dm;
        rx_dst_pan = dp; rx_dst_addr = da; rx_fcs_ok = fcs;
        rx_done = 1'b1; irq_clear = clr;
        @(negedge clk); #1;
        rx_done = 1'b0; irq_clear = 1'b0;
    endtask

    task automatic clear_irqs();
        @(negedge clk); #1 irq_clear = 1'b1;
        @(negedge clk); #1 irq_clear = 1'b0;
    endtask

    task automatic c1(input logic got, input logic exp, input string tag);
        chk({7'd0, got}, {7'd0, exp}, tag);
    endtask

    localparam logic [15:0] MY_S = 16'h1234;
    localparam logic [15:0] MY_P = 16'hABCD;
    localparam logic [63:0] MY_E = 64'h0102_0304_0506_0708;

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        c1(irq_end, 0, "R12 reset irq_end");
        c1(frame_accept, 0, "R12 reset frame_accept");
        chk(rx_status, 8'h00, "R12 reset rx_status");

        own_short = MY_S; own_pan = MY_P; own_ext = MY_E;

        // R3 R6 R9: own short, ack requested
        send(3'd1, 1, 2'd2, MY_P, {48'h0, MY_S}, 1);
        c1(frame_accept, 1, "R6 own short accepted");
        c1(irq_match, 1, "R3 own short match");
        c1(ack_req, 1, "R9 ack pulse");
        @(negedge clk);
        c1(ack_req, 0, "R9 ack one cycle");

        // R11 clear
        clear_irqs();
        c1(irq_end, 0, "R11 irq_end cleared");
        c1(irq_match, 0, "R11 irq_match cleared");

        // R3 broadcast
        send(3'd1, 0, 2'd2, 16'hFFFF, 64'hFFFF, 1);
        c1(frame_accept, 1, "R3 broadcast accepted");
        c1(ack_req, 0, "R9 no ack without request bit");

        // R4 R6 foreign address
        clear_irqs();
        send(3'd1, 1, 2'd2, MY_P, 64'h5555, 1);
        c1(frame_accept, 0, "R6 foreign rejected");
        c1(irq_match, 0, "R4 foreign no match");
        c1(irq_end, 1, "R1 irq_end on rejected frame");

        // R1 R2 bad FCS, extended match
        clear_irqs();
        send(3'd3, 1, 2'd3, MY_P, MY_E, 0);
        c1(irq_end, 1, "R1 irq_end on bad FCS");
        c1(crc_valid, 0, "R2 crc_valid low");
        chk(rx_status, 8'h6B, "R2 status byte");
        c1(ack_req, 0, "R9 no ack on bad FCS");
        c1(frame_accept, 1, "R3 extended match accepted");

        // R10 ack suppressed
        ack_off = 1;
        send(3'd1, 1, 2'd2, MY_P, {48'h0, MY_S}, 1);
        c1(ack_req, 0, "R10 ack suppressed");
        ack_off = 0;

        // R7 reserved dropped
        clear_irqs();
        send(3'd5, 0, 2'd2, MY_P, {48'h0, MY_S}, 1);
        c1(frame_accept, 0, "R7 reserved dropped");
        c1(irq_match, 1, "R4 match on reserved type");

        // R8 filtered like data
        rsv_en = 1; rsv_as_data = 1;
        send(3'd6, 0, 2'd2, MY_P, 64'h5555, 1);
        c1(frame_accept, 0, "R8 filtered reserved foreign");
        send(3'd6, 0, 2'd2, MY_P, {48'h0, MY_S}, 1);
        c1(frame_accept, 1, "R8 filtered reserved own");

        // R8 bypass
        rsv_as_data = 0;
        send(3'd7, 0, 2'd0, 16'h0, 64'h0, 1);
        c1(frame_accept, 1, "R8 bypass accepted");
        rsv_en = 0;

        // R3 no destination
        clear_irqs();
        send(3'd1, 1, 2'd0, MY_P, {48'h0, MY_S}, 1);
        c1(irq_match, 0, "R3 mode 0 never matches");

        // R11 clear with simultaneous frame
        send(3'd1, 0, 2'd2, MY_P, {48'h0, MY_S}, 1, 1);
        c1(irq_end, 1, "R11 frame wins over clear");
        c1(irq_match, 1, "R11 match wins over clear");

        // R12 R2 hold
        repeat (5) @(negedge clk);
        c1(frame_accept, 1, "R12 accept held");
        c1(crc_valid, 1, "R2 crc held");

        // R5 promiscuous
        own_short = 0; own_pan = 0; own_ext = 0; prom_en = 1;
        clear_irqs();
        send(3'd1, 0, 2'd2, 16'h1111, 64'h2222, 1);
        c1(frame_accept, 1, "R5 promiscuous accepts");
        c1(irq_match, 0, "R4 promiscuous no match");
        c1(rx_status[4], 1, "R5 status prom bit");
        send(3'd6, 0, 2'd2, 16'h1111, 64'h2222, 1);
        c1(frame_accept, 1, "R5 promiscuous reserved");
        own_short = 16'h0001;
        send(3'd1, 0, 2'd2, 16'h1111, 64'h2222, 1);
        c1(frame_accept, 0, "R5 nonzero identity filters");
        prom_en = 0;

        // random traffic, checked by the model each cycle
        for (int i = 0; i < 600; i++) begin
            logic [15:0] dp;
            logic [63:0] da;
            if (i % 50 == 0) begin
                own_short = $urandom_range(3) == 0 ? 16'h0 : 16'(($urandom));
                own_pan   = $urandom_range(3) == 0 ? 16'h0 : 16'(($urandom));
                own_ext   = $urandom_range(3) == 0 ? 64'h0 : {32'($urandom), 32'($urandom)};
                prom_en = 1'($urandom); ack_off = 1'($urandom);
                rsv_en = 1'($urandom); rsv_as_data = 1'($urandom);
            end
            case ($urandom_range(2))
                0: dp = own_pan;
                1: dp = 16'hFFFF;
                default: dp = 16'($urandom);
            endcase
            case ($urandom_range(3))
                0: da = {48'h0, own_short};
                1: da = 64'hFFFF;
                2: da = own_ext;
                default: da = {32'($urandom), 32'($urandom)};
            endcase
            send(3'($urandom), 1'($urandom), 2'($urandom), dp, da, 1'($urandom),
                 $urandom_range(7) == 0);
            if ($urandom_range(3) == 0) clear_irqs();
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule